// File: doc/BRIEF.md
# Reset Cause Recorder

This block keeps the record that firmware reads after a restart to learn why the chip last left reset or sleep. Fourteen single-cycle event strobes come from detectors elsewhere in the chip. Each strobe changes only its own few flag bits and leaves every other bit as it was. The flags sit in three registers: a status byte, a reset flag byte and a three-bit auxiliary field. The block also supplies the program counter that execution resumes from. A reset restarts at address zero. A wake from sleep resumes two bytes past the address supplied on `pc_i`.

Most flags are active-low: an event clears its flag. The two stack flags are active-high: an event sets them. Firmware rewrites the flags through a small write port so that the next cause can be told apart from the last one. A combinational read port returns any of the three registers.

Power-on, brown-out and regulator-fault events reload most of the state, so they take priority in that order. The other events touch separate flag bits and apply together. The only exception is the timeout/power-down pair in the status byte, which has its own priority order. A small two-state machine, `RS_ZERO` and `RS_WAKE`, records whether the last restart was a reset or a wake. Its state selects the restart address.

Top module: `rst_cause_rec`

## Requirements
- R1: Event input `ev_i` bit map: 0 power-on, 1 brown-out, 2 pin reset while running, 3 pin reset while asleep, 4 watchdog timeout reset, 5 watchdog wake, 6 window violation, 7 interrupt wake, 8 reset instruction, 9 stack overflow, 10 stack underflow, 11 fuse fault, 12 regulator fault, 13 memory violation. Power-on loads the status byte with 0x60, the flag byte with 0x3D and the auxiliary field with 3'b111. Holding `rst_n` low has the same effect.
- R2: Read select encoding: 0 returns the status byte, 1 the flag byte, 2 the auxiliary field zero-extended, and 3 returns 0. In the status byte, bit 6 is timeout, bit 5 is power-down, bits 4:0 are the arithmetic flags, and bit 7 reads 0.
- R3: Brown-out loads the status byte with 0x60. It sets flag bits 7:2 to 001111, clears flag bit 0 and keeps flag bit 1. It sets auxiliary bit 1 and keeps auxiliary bits 2 and 0.
- R4: Regulator fault loads the status byte with 0x60. It sets flag bits 7:1 to 0011110 and keeps flag bit 0. It clears auxiliary bit 2, sets auxiliary bit 0 and keeps auxiliary bit 1.
- R5: Each of these events changes one bit and nothing else. Stack overflow sets flag bit 7. Stack underflow sets flag bit 6. Window violation clears flag bit 5. Watchdog timeout reset clears flag bit 4. A pin reset of either kind clears flag bit 3. The reset instruction clears flag bit 2. A fuse fault clears auxiliary bit 0. A memory violation clears auxiliary bit 1.
- R6: Events change timeout/power-down as follows. Watchdog timeout reset clears timeout and keeps power-down. Pin reset while asleep gives timeout 1 and power-down 0. Watchdog wake gives 0 and 0. Interrupt wake gives 1 and 0. If several of these arrive together, they win in that order.
- R7: Priority is power-on, then brown-out, then regulator fault. Any lower event in the same cycle is ignored. With none of these three present, all other events in the cycle apply together.
- R8: After any event other than the two wakes (bits 5 and 7), `restart_pc_o` is 0. After a wake with no such event, it is `pc_i` + 2, with `pc_i` sampled in the event cycle. It holds otherwise.
- R9: A write uses select 0 for status bits 4:0 only, 1 for the whole flag byte and 2 for auxiliary bits 2:0. A write in a cycle with any event bit set is dropped.
- R10: With no event and no write, every register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ev_i | input | 14 | Event strobes, bit map in R1 |
| pc_i | input | PC_W | Current program counter, used by wake events |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | 8 | Selected register value |
| restart_pc_o | output | PC_W | Restart program counter |

## Verification
Every register and the restart address change on the clock edge that samples the event or write, so each result is due one edge after the stimulus. The read port is combinational. The bench drives inputs on the falling edge. It reads all three registers and the restart address in short steps just after the next rising edge, before any input moves again. A bench model applies the same inputs in the same cycle, so every unchanged bit is compared against its own prior value. The model is walked through every single event and every pair of events, starting from varied prior states.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int NUM_EV = 14;

    localparam int EV_POR      = 0;
    localparam int EV_BOR      = 1;
    localparam int EV_PIN_RUN  = 2;
    localparam int EV_PIN_SLP  = 3;
    localparam int EV_WDT_RST  = 4;
    localparam int EV_WDT_WAKE = 5;
    localparam int EV_WIN      = 6;
    localparam int EV_INT_WAKE = 7;
    localparam int EV_SW_RST   = 8;
    localparam int EV_STK_OVF  = 9;
    localparam int EV_STK_UNF  = 10;
    localparam int EV_FUSE     = 11;
    localparam int EV_VREG     = 12;
    localparam int EV_MEM      = 13;

    localparam int FL_BOR = 0;
    localparam int FL_POR = 1;
    localparam int FL_SWR = 2;
    localparam int FL_PIN = 3;
    localparam int FL_WDT = 4;
    localparam int FL_WIN = 5;
    localparam int FL_UNF = 6;
    localparam int FL_OVF = 7;

    localparam int AX_FUSE = 0;
    localparam int AX_MEM  = 1;
    localparam int AX_VREG = 2;

    localparam logic [NUM_EV-1:0] WAKE_MASK  =
        (NUM_EV'(1) << EV_WDT_WAKE) | (NUM_EV'(1) << EV_INT_WAKE);
    localparam logic [NUM_EV-1:0] RESET_MASK = ~WAKE_MASK;

    localparam logic [7:0] FLAG_COLD = 8'h3D;
    localparam logic [2:0] AUX_COLD  = 3'b111;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_FLAG = 2'd1;
    localparam logic [1:0] SEL_AUX  = 2'd2;

    typedef struct packed {
        logic       to;
        logic       pd;
        logic [4:0] ar;
        logic [7:0] fl;
        logic [2:0] ax;
    } rc_regs_t;

    typedef enum logic {
        RS_ZERO = 1'b0,
        RS_WAKE = 1'b1
    } restart_e;
endpackage

// File: rtl/rcr_flag_next.sv
module rcr_flag_next
    import rcr_pkg::*;
(
    input  rc_regs_t          cur,
    input  logic [NUM_EV-1:0] ev,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output rc_regs_t          nxt
);
    always_comb begin
        nxt = cur;
        if (ev[EV_POR]) begin
            nxt.to = 1'b1;
            nxt.pd = 1'b1;
            nxt.ar = '0;
            nxt.fl = FLAG_COLD;
            nxt.ax = AUX_COLD;
        end else if (ev[EV_BOR]) begin
            nxt.to = 1'b1;
            nxt.pd = 1'b1;
            nxt.ar = '0;
            nxt.fl = {6'b001111, cur.fl[FL_POR], 1'b0};
            nxt.ax[AX_MEM] = 1'b1;
        end else if (ev[EV_VREG]) begin
            nxt.to = 1'b1;
            nxt.pd = 1'b1;
            nxt.ar = '0;
            nxt.fl = {7'b0011110, cur.fl[FL_BOR]};
            nxt.ax[AX_VREG] = 1'b0;
            nxt.ax[AX_FUSE] = 1'b1;
        end else begin
            if (ev[EV_STK_OVF])                nxt.fl[FL_OVF] = 1'b1;
            if (ev[EV_STK_UNF])                nxt.fl[FL_UNF] = 1'b1;
            if (ev[EV_WIN])                    nxt.fl[FL_WIN] = 1'b0;
            if (ev[EV_WDT_RST])                nxt.fl[FL_WDT] = 1'b0;
            if (ev[EV_PIN_RUN] || ev[EV_PIN_SLP]) nxt.fl[FL_PIN] = 1'b0;
            if (ev[EV_SW_RST])                 nxt.fl[FL_SWR] = 1'b0;
            if (ev[EV_FUSE])                   nxt.ax[AX_FUSE] = 1'b0;
            if (ev[EV_MEM])                    nxt.ax[AX_MEM]  = 1'b0;

            if (ev[EV_WDT_RST]) begin
                nxt.to = 1'b0;
            end else if (ev[EV_PIN_SLP]) begin
                nxt.to = 1'b1;
                nxt.pd = 1'b0;
            end else if (ev[EV_WDT_WAKE]) begin
                nxt.to = 1'b0;
                nxt.pd = 1'b0;
            end else if (ev[EV_INT_WAKE]) begin
                nxt.to = 1'b1;
                nxt.pd = 1'b0;
            end
        end

        if (ev == '0 && wr_en) begin
            unique case (wr_sel)
                SEL_STAT: nxt.ar = wr_data[4:0];
                SEL_FLAG: nxt.fl = wr_data;
                SEL_AUX:  nxt.ax = wr_data[2:0];
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/rcr_restart_fsm.sv
module rcr_restart_fsm
    import rcr_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic [PC_W-1:0]   pc_i,
    output logic [PC_W-1:0]   restart_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    restart_e        state_q, state_d;
    logic [PC_W-1:0] wake_pc_q;
    logic            any_reset, any_wake;

    assign any_reset = |(ev & RESET_MASK);
    assign any_wake  = |(ev & WAKE_MASK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_ZERO: if (!any_reset && any_wake) state_d = RS_WAKE;
            RS_WAKE: if (any_reset)              state_d = RS_ZERO;
            default: state_d = RS_ZERO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RS_ZERO;
            wake_pc_q <= '0;
        end else begin
            state_q <= state_d;
            if (!any_reset && any_wake) wake_pc_q <= pc_i + STEP;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_WAKE: restart_pc = wake_pc_q;
            default: restart_pc = '0;
        endcase
    end
endmodule

// File: rtl/rcr_read_mux.sv
module rcr_read_mux (
    input  logic [1:0] sel,
    input  logic [7:0] stat_byte,
    input  logic [7:0] flag_byte,
    input  logic [7:0] aux_byte,
    output logic [7:0] rd_data
);
    always_comb begin
        unique case (sel)
            2'd0:    rd_data = stat_byte;
            2'd1:    rd_data = flag_byte;
            2'd2:    rd_data = aux_byte;
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rcr_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [13:0]       ev_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [7:0]        wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [7:0]        rd_data_o,
    output logic [PC_W-1:0]   restart_pc_o
);
    localparam rc_regs_t COLD = '{to: 1'b1, pd: 1'b1, ar: 5'd0,
                                  fl: FLAG_COLD, ax: AUX_COLD};

    rc_regs_t   regs_q, regs_d;
    logic [7:0] stat_byte, flag_byte, aux_byte;

    rcr_flag_next u_next (
        .cur     (regs_q),
        .ev      (ev_i),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .nxt     (regs_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= COLD;
        else        regs_q <= regs_d;
    end

    assign stat_byte = {1'b0, regs_q.to, regs_q.pd, regs_q.ar};
    assign flag_byte = regs_q.fl;
    assign aux_byte  = {5'b0, regs_q.ax};

    rcr_read_mux u_rd (
        .sel       (rd_sel_i),
        .stat_byte (stat_byte),
        .flag_byte (flag_byte),
        .aux_byte  (aux_byte),
        .rd_data   (rd_data_o)
    );

    rcr_restart_fsm #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev_i),
        .pc_i       (pc_i),
        .restart_pc (restart_pc_o)
    );
endmodule

// File: rtl/rst_cause_rec_chk.sv
module rst_cause_rec_chk #(
    parameter int PC_W    = 16,
    parameter int PC_STEP = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [13:0]     ev,
    input logic [PC_W-1:0] pc,
    input logic            wr_en,
    input logic [1:0]      wr_sel,
    input logic [7:0]      stat,
    input logic [7:0]      fl,
    input logic [7:0]      aux,
    input logic [PC_W-1:0] rpc
);
    logic hi_prio;
    assign hi_prio = ev[0] | ev[1] | ev[12];

    p_cold_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev[0] |=> (stat == 8'h60 && fl == 8'h3D && aux == 8'h07));

    p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[9] && !hi_prio) |=> fl[7]);

    p_wdt_clears_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[4] && !hi_prio) |=> !stat[6]);

    p_reset_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev & 14'h3F5F)) |=> (rpc == '0));

    p_wake_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & 14'h3F5F) == '0 && |(ev & 14'h00A0))
        |=> (rpc == $past(pc) + PC_W'(PC_STEP)));

    p_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0 && (ev & ~14'h28A0) == '0 && wr_en && wr_sel == 2'd1)
        |=> $stable(fl));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0 && !wr_en) |=> ($stable(stat) && $stable(fl) && $stable(aux)));
endmodule

bind rst_cause_rec rst_cause_rec_chk #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev_i),
    .pc     (pc_i),
    .wr_en  (wr_en_i),
    .wr_sel (wr_sel_i),
    .stat   (stat_byte),
    .fl     (flag_byte),
    .aux    (aux_byte),
    .rpc    (restart_pc_o)
);

// File: tb/rst_cause_rec_test.sv
`timescale 1ns/100ps
module rst_cause_rec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ev_i = '0;
    logic [15:0] pc_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [1:0]  rd_sel_i = '0;
    logic [7:0]  rd_data_o;
    logic [15:0] restart_pc_o;

    int total = 0;
    int bad   = 0;

    logic       m_to, m_pd;
    logic [4:0] m_ar;
    logic [7:0] m_fl;
    logic [2:0] m_ax;
    logic [15:0] m_pc;

    always #2.5 clk = ~clk;

    rst_cause_rec uut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .pc_i(pc_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .restart_pc_o(restart_pc_o)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model_cold();
        m_to = 1'b1; m_pd = 1'b1; m_ar = '0; m_fl = 8'h3D; m_ax = 3'b111; m_pc = '0;
    endtask

    task automatic model_step(input logic [13:0] e, input logic we, input logic [1:0] ws,
                              input logic [7:0] wd, input logic [15:0] pcv);
        if (e[0]) begin
            model_cold();
        end else if (e[1]) begin
            m_to = 1; m_pd = 1; m_ar = '0;
            m_fl = {6'b001111, m_fl[1], 1'b0};
            m_ax[1] = 1'b1;
        end else if (e[12]) begin
            m_to = 1; m_pd = 1; m_ar = '0;
            m_fl = {7'b0011110, m_fl[0]};
            m_ax[2] = 1'b0; m_ax[0] = 1'b1;
        end else begin
            if (e[9])         m_fl[7] = 1'b1;
            if (e[10])        m_fl[6] = 1'b1;
            if (e[6])         m_fl[5] = 1'b0;
            if (e[4])         m_fl[4] = 1'b0;
            if (e[2] || e[3]) m_fl[3] = 1'b0;
            if (e[8])         m_fl[2] = 1'b0;
            if (e[11])        m_ax[0] = 1'b0;
            if (e[13])        m_ax[1] = 1'b0;
            if (e[4])      m_to = 1'b0;
            else if (e[3]) begin m_to = 1'b1; m_pd = 1'b0; end
            else if (e[5]) begin m_to = 1'b0; m_pd = 1'b0; end
            else if (e[7]) begin m_to = 1'b1; m_pd = 1'b0; end
        end
        if (e == '0 && we) begin
            if (ws == 2'd0) m_ar = wd[4:0];
            else if (ws == 2'd1) m_fl = wd;
            else if (ws == 2'd2) m_ax = wd[2:0];
        end
        if (e[13:8] != '0 || e[6] || e[4:0] != '0) m_pc = '0;
        else if (e[5] || e[7]) m_pc = pcv + 16'd2;
    endtask

    task automatic check_all(input string tag);
        rd_sel_i = 2'd0; #0.4;
        chk(tag, "status", int'(rd_data_o), int'({1'b0, m_to, m_pd, m_ar}));
        rd_sel_i = 2'd1; #0.4;
        chk(tag, "flags", int'(rd_data_o), int'(m_fl));
        rd_sel_i = 2'd2; #0.4;
        chk(tag, "aux", int'(rd_data_o), int'({5'b0, m_ax}));
        chk(tag, "restart_pc", int'(restart_pc_o), int'(m_pc));
    endtask

    task automatic step(input logic [13:0] e, input logic we, input logic [1:0] ws,
                        input logic [7:0] wd, input string tag);
        logic [15:0] pcv;
        @(negedge clk);
        pcv = 16'($urandom);
        ev_i = e; pc_i = pcv; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
        model_step(e, we, ws, wd, pcv);
        @(posedge clk); #0.3;
        check_all(tag);
    endtask

    function automatic string ev_tag(input int i);
        case (i)
            0: return "R1";
            1: return "R3";
            12: return "R4";
            3, 4: return "R6";
            5, 7: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic prep(input int k);
        case (k % 4)
            0: step(14'b1 << 0, 0, 0, 0, "R1");
            1: step(14'b1 << 4, 0, 0, 0, "R6");
            2: step(14'b1 << 7, 0, 0, 0, "R8");
            default: step(14'b1 << 5, 0, 0, 0, "R8");
        endcase
        step('0, 1, 2'd0, 8'($urandom), "R9");
        step('0, 1, 2'd1, 8'($urandom), "R9");
        step('0, 1, 2'd2, 8'($urandom), "R9");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_cold();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.3;
        check_all("R1");
        rd_sel_i = 2'd3; #0.4;
        chk("R2", "unused select", int'(rd_data_o), 0);

        for (int e = 0; e < 14; e++) begin
            for (int k = 0; k < 4; k++) begin
                prep(k);
                step(14'b1 << e, 0, 0, 0, ev_tag(e));
            end
        end

        for (int a = 0; a < 14; a++) begin
            for (int b = a + 1; b < 14; b++) begin
                prep(a + b);
                step((14'b1 << a) | (14'b1 << b), 0, 0, 0, "R7");
            end
        end

        for (int e = 0; e < 14; e++) begin
            prep(e);
            step(14'b1 << e, 1, 2'(e % 3), 8'($urandom), "R9");
        end

        prep(1);
        step('0, 1, 2'd3, 8'hFF, "R9");
        for (int i = 0; i < 4; i++) step('0, 0, 2'd1, 8'h00, "R10");

        prep(2);
        rd_sel_i = 2'd0; #0.4;
        chk("R2", "status bit7", int'(rd_data_o[7]), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule